// File: doc/BRIEF.md
# Complementary Gate Drive Generator with Dead Band

This block turns one synchronous PWM reference into the two gate drives of a single half-bridge leg. While the reference is high the high-side switch is driven; while it is low the low-side switch is driven. Every change of the reference first removes the drive from the side that was on. The other side is then held off for a programmable number of clock cycles, so the two switches are never on at the same time.

The dead band is an 8-bit count of system clock cycles. At a 100 MHz clock this spans 0 to 2.55 µs, which covers the usual 100 to 500 ns range. A count of zero gives plain complementary outputs. An output enable forces both pins to their inactive level at once, without waiting for a clock edge. Two polarity bits choose the active level of each pin separately. The reference itself is produced elsewhere and must be synchronous to `clk`.

Top module: `cpwm_deadtime`

## Requirements
- R1: The high-side and low-side drives are never active in the same cycle, for any input sequence and any polarity setting.
- R2: When `ref_in` is first sampled high at clock edge E, the high side becomes active after edge E+D, where D is the value of `dead_cycles` sampled at edge E. Both sides are inactive after edges E to E+D-1. With D=0 the high side is active right after edge E.
- R3: When `ref_in` is first sampled low at edge E, the low side becomes active after edge E+D, with both sides inactive between. With D=0 the low side is active right after edge E.
- R4: Turn-off has no delay. The side that was active is inactive right after the first edge that samples the opposite reference level.
- R5: If the reference pulse lasts fewer cycles than the dead band, that pulse's side never turns on. The other side turns on D cycles after the trailing reference edge.
- R6: After reset is released, both sides stay inactive for D edges, counted from the first clock edge. The side selected by the reference then turns on.
- R7: A reference held low (0% duty) keeps the high side inactive indefinitely. A reference held high (100% duty) keeps the high side active indefinitely.
- R8: While `out_en` is low, both pins show their inactive level in the same cycle, with no clock edge needed. The dead-band logic keeps tracking the reference, so on re-enable the pins show the tracked state.
- R9: The polarity inputs work per pin. 0 means active-high and 1 means active-low. They act only on the pin level, not on timing.
- R10: `dead_cycles` is sampled only at reference edges. Changing it during a dead band does not change the length of that dead band.
- R11: During reset both logical drives are inactive, so each pin equals its polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ref_in | input | 1 | PWM reference; high selects the high side |
| dead_cycles | input | 8 | Dead band length in clock cycles |
| out_en | input | 1 | Output enable; low forces both pins inactive |
| pol_hi | input | 1 | High-side polarity: 0 active-high, 1 active-low |
| pol_lo | input | 1 | Low-side polarity: 0 active-high, 1 active-low |
| drv_hi | output | 1 | High-side gate drive pin |
| drv_lo | output | 1 | Low-side gate drive pin |

## Verification
Several properties are checked on every cycle:
- the pins never show both sides active;
- every reference edge with a nonzero count leaves both sides off for the following cycle;
- each side drops on the edge after the reference leaves its level;
- a disabled output shows only inactive levels;
- a running count only decrements, whatever happens to `dead_cycles`.

Other behaviours can only be shown by the directed scenarios:
- the exact cycle a side turns on for short, zero and long dead bands;
- the swallowed short pulse;
- the first turn-on after reset;
- steady 0% and 100% references;
- tracking through a disabled period;
- the pin levels under each polarity combination.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int SIDE_HI = 0;
  localparam int SIDE_LO = 1;
  localparam int N_SIDES = 2;
endpackage

// File: rtl/cpwm_edge_det.sv
// Flags a reference transition; the first cycle after reset also counts
// as a transition so the initial side obeys the dead band.
module cpwm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic ref_edge
);
  logic ref_q, ref_d;
  logic armed_q, armed_d;

  always_comb begin
    ref_d    = ref_in;
    armed_d  = 1'b1;
    ref_edge = (ref_in ^ ref_q) | ~armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/cpwm_dead_cnt.sv
// Dead band down-counter; reloads on each reference edge.
module cpwm_dead_cnt #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] dead_val,
  output logic            gap_done_nxt
);
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            cnt_busy;

  always_comb begin
    cnt_busy = (cnt_q != '0);
    cnt_en   = load | cnt_busy;
    if (load)          cnt_d = dead_val;
    else if (cnt_busy) cnt_d = cnt_q - 1'b1;
    else               cnt_d = cnt_q;
    gap_done_nxt = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // A running dead band only counts down; dead_val is ignored until the next edge.
  assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == DT_W'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/cpwm_out_stage.sv
// Enable gating and per-pin polarity, applied after the dead-band logic.
module cpwm_out_stage #(
  parameter int N = 2
) (
  input  logic [N-1:0] act,
  input  logic         en,
  input  logic [N-1:0] pol,
  output logic [N-1:0] drv
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    assign drv[g] = (act[g] & en) ^ pol[g];
  end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
  import cpwm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_in,
  input  logic [DT_W-1:0] dead_cycles,
  input  logic            out_en,
  input  logic            pol_hi,
  input  logic            pol_lo,
  output logic            drv_hi,
  output logic            drv_lo
);
  logic                 ref_edge;
  logic                 gap_done_nxt;
  logic [N_SIDES-1:0]   act_q, act_d;
  logic                 act_en;
  logic [N_SIDES-1:0]   pol_v, drv_v;

  cpwm_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .ref_edge (ref_edge)
  );

  cpwm_dead_cnt #(.DT_W(DT_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (ref_edge),
    .dead_val     (dead_cycles),
    .gap_done_nxt (gap_done_nxt)
  );

  // A side is granted only when the reference selects it and no dead band runs.
  always_comb begin
    act_en           = ref_edge | gap_done_nxt;
    act_d[SIDE_HI]   =  ref_in & gap_done_nxt;
    act_d[SIDE_LO]   = ~ref_in & gap_done_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= '0;
    else if (act_en) act_q <= act_d;
  end

  assign pol_v[SIDE_HI] = pol_hi;
  assign pol_v[SIDE_LO] = pol_lo;

  cpwm_out_stage #(.N(N_SIDES)) u_out (
    .act (act_q),
    .en  (out_en),
    .pol (pol_v),
    .drv (drv_v)
  );

  assign drv_hi = drv_v[SIDE_HI];
  assign drv_lo = drv_v[SIDE_LO];

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !((drv_hi ^ pol_hi) && (drv_lo ^ pol_lo)));

  // Covers R3 as well: a nonzero dead band leaves both sides off after the edge.
  assert_dead_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && dead_cycles != '0) |=> (act_q == '0));

  assert_fast_off_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_in |=> !act_q[SIDE_HI]);

  assert_fast_off_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ref_in |=> !act_q[SIDE_LO]);

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (drv_hi == pol_hi && drv_lo == pol_lo));
endmodule

// File: tb/cpwm_deadtime_tb.sv
module cpwm_deadtime_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_in;
  logic [7:0] dead_cycles;
  logic       out_en, pol_hi, pol_lo;
  logic       drv_hi, drv_lo;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cpwm_deadtime u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .dead_cycles(dead_cycles),
    .out_en(out_en), .pol_hi(pol_hi), .pol_lo(pol_lo),
    .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  function automatic logic hi_on(); return drv_hi ^ pol_hi; endfunction
  function automatic logic lo_on(); return drv_lo ^ pol_lo; endfunction

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_in = 1'b0; dead_cycles = 8'd5;
    out_en = 1'b1; pol_hi = 1'b0; pol_lo = 1'b0;
    #1;
    chk(drv_hi, 1'b0, "R11 hi pin in reset");
    chk(drv_lo, 1'b0, "R11 lo pin in reset");
    pol_hi = 1'b1; #1;
    chk(drv_hi, 1'b1, "R11 inverted hi pin in reset");
    pol_hi = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    for (int j = 1; j <= 7; j++) begin
      tick();
      chk(lo_on(), j > 5, "R6 first turn-on after reset");
      chk(hi_on(), 1'b0, "R6 hi stays off");
    end
  endtask

  task automatic t_rise(input int d);
    dead_cycles = 8'(d); ref_in = 1'b1;
    for (int j = 1; j <= d + 2; j++) begin
      tick();
      chk(hi_on(), j > d, "R2 hi turn-on cycle");
      chk(lo_on(), 1'b0, "R4 lo off at once");
      chk(hi_on() & lo_on(), 1'b0, "R1 overlap");
    end
  endtask

  task automatic t_fall(input int d);
    dead_cycles = 8'(d); ref_in = 1'b0;
    for (int j = 1; j <= d + 2; j++) begin
      tick();
      chk(lo_on(), j > d, "R3 lo turn-on cycle");
      chk(hi_on(), 1'b0, "R4 hi off at once");
      chk(hi_on() & lo_on(), 1'b0, "R1 overlap");
    end
  endtask

  task automatic t_short_pulse();
    dead_cycles = 8'd6; ref_in = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      tick();
      chk(hi_on(), 1'b0, "R5 short pulse hi off");
    end
    ref_in = 1'b0;
    for (int j = 1; j <= 8; j++) begin
      tick();
      chk(hi_on(), 1'b0, "R5 short pulse hi never on");
      chk(lo_on(), j > 6, "R5 lo after full dead band");
    end
  endtask

  task automatic t_steady();
    ref_in = 1'b0;
    for (int j = 0; j < 40; j++) begin
      tick();
      chk(hi_on(), 1'b0, "R7 0% duty hi off");
    end
    dead_cycles = 8'd2; ref_in = 1'b1;
    tick(); tick(); tick();
    for (int j = 0; j < 40; j++) begin
      tick();
      chk(hi_on(), 1'b1, "R7 100% duty hi on");
    end
  endtask

  task automatic t_dead_change();
    dead_cycles = 8'd8; ref_in = 1'b0;
    tick(); tick();
    dead_cycles = 8'd1;
    for (int j = 3; j <= 10; j++) begin
      tick();
      chk(lo_on(), j > 8, "R10 dead band length latched at edge");
    end
  endtask

  task automatic t_enable();
    out_en = 1'b0; #1;
    chk(drv_lo, pol_lo, "R8 lo forced inactive");
    chk(drv_hi, pol_hi, "R8 hi forced inactive");
    dead_cycles = 8'd2; ref_in = 1'b1;
    for (int j = 0; j < 4; j++) begin
      tick();
      chk(drv_hi, pol_hi, "R8 hi held inactive");
    end
    out_en = 1'b1; #1;
    chk(hi_on(), 1'b1, "R8 tracked state on re-enable");
    chk(lo_on(), 1'b0, "R8 lo off on re-enable");
  endtask

  task automatic t_polarity();
    pol_hi = 1'b1; #1;
    chk(drv_hi, 1'b0, "R9 active-low hi pin");
    chk(drv_lo, 1'b0, "R9 lo inactive active-high");
    pol_lo = 1'b1; #1;
    chk(drv_lo, 1'b1, "R9 lo inactive active-low");
    out_en = 1'b0; #1;
    chk(drv_hi, 1'b1, "R9 hi inactive level active-low");
    out_en = 1'b1;
    dead_cycles = 8'd3; ref_in = 1'b0;
    for (int j = 1; j <= 5; j++) begin
      tick();
      chk(hi_on() & lo_on(), 1'b0, "R1 overlap inverted");
      chk(lo_on(), j > 3, "R9 timing unchanged by polarity");
    end
    pol_hi = 1'b0; pol_lo = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rise(5);
    t_fall(5);
    t_rise(0);
    t_fall(0);
    t_rise(200);
    t_fall(3);
    t_short_pulse();
    t_steady();
    t_dead_change();
    t_enable();
    t_polarity();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule